// File: doc/BRIEF.md
# Slow-Clock System Reset Sequencer

This block produces the chip-level reset lines from two causes: a power-on indication from the supply monitor and an active-low external reset pin. It runs only on the slow clock. It drives three active-low outputs: a processor reset, a peripheral reset and a driver for the reset pin. A three-bit read-only field records what caused the most recent reset. A small configuration port sets two values. The first is a user-reset enable bit. The second is a 4-bit length code for the pulse the block drives onto the reset pin.

The power-on input clears the state register asynchronously, so all outputs assert with no clock running. After the power-on input releases, a fixed startup count on the slow clock must expire before anything releases. A low on the reset pin passes through a two-stage synchroniser. If the enable bit is set, that low starts a user reset: the block pulses the pin driver low, waits for the pin to read high again, then runs a three-cycle processor startup before it releases the resets.

The sequencer has four states. ST_STARTUP is the state after power-on. It moves to ST_RUN when the startup count expires. ST_RUN moves to ST_USER_HOLD when the synchronised pin is low and the enable bit is set. ST_USER_HOLD moves to ST_PROC_START once the pin pulse has ended and the synchronised pin is high. ST_PROC_START moves to ST_RUN after three cycles, or back to ST_USER_HOLD if the synchronised pin drops again.

Top module: `slowclk_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `proc_rst_n`, `periph_rst_n` and `pin_drive_n` are all 0, with no clock edge needed. The configuration resets to enable = 0 and length code = 0.
- R2: After `por_n` rises, all three outputs stay low until the STARTUP_LEN-th rising clock edge (default 8). Then both internal resets release and the pin driver goes high.
- R3: `periph_rst_n` always equals `proc_rst_n`, so both resets release in the same cycle.
- R4: With enable = 1, a low on `pin_in` that is first sampled at rising edge k brings both internal resets low after edge k+2.
- R5: On leaving a user reset, the internal resets release at the sixth rising edge counted from the first edge that samples `pin_in` high again. This assumes the pin pulse is already over.
- R6: When the internal resets release after a user reset, `rst_cause` becomes 4. `rst_cause` changes at no other time during normal operation.
- R7: In a user reset, `pin_drive_n` is low for exactly 2^(L+1) cycles, where L is the 4-bit length code. The pulse starts in the same cycle the internal resets assert.
- R8: If `pin_in` stays low past the end of the pulse, the internal resets stay low. They release per R5 once the pin returns high.
- R9: With enable = 0, a low on `pin_in` causes no reset and leaves `rst_cause` unchanged.
- R10: A configuration write made while the internal resets are asserted is ignored.
- R11: `rst_cause` is a 3-bit read-only field. It reads 0 after a power-up reset completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| por_n | input | 1 | Power-on indication; low means the supply is low (asynchronous) |
| pin_in | input | 1 | Raw level of the external reset pin, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_urst_en | input | 1 | Write data: user-reset enable |
| cfg_ext_len | input | 4 | Write data: pin pulse length code L |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| pin_drive_n | output | 1 | Reset-pin driver, low drives the pin low |
| rst_cause | output | 3 | Last reset cause: 0 power-up, 4 user |

## Verification
The assertions check properties that must hold on every cycle. All outputs are low while power-on is low. The two internal resets move together. The pin driver is never low while the processor reset is released. The cause field holds only legal codes, and it changes only at the moment the processor reset releases.

Other behaviours depend on timing across a whole sequence, so only the bench scenarios can show them. These are the exact startup length, the two-cycle synchroniser plus three-cycle startup latency, the 2^(L+1) pulse width, the hold while the pin is kept low, and the enable bit suppressing resets. The same applies to writes being dropped during a reset, which only shows up in a later reset.

// File: rtl/slowclk_reset_pkg.sv
package slowclk_reset_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP,
        ST_RUN,
        ST_USER_HOLD,
        ST_PROC_START
    } rst_state_e;

    localparam logic [2:0] CAUSE_POWERUP = 3'd0;
    localparam logic [2:0] CAUSE_USER    = 3'd4;

endpackage

// File: rtl/slowclk_pin_sync.sv
module slowclk_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[s] <= RESET_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/slowclk_reset_cfg.sv
module slowclk_reset_cfg #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_open,
    input  logic             cfg_we,
    input  logic             cfg_urst_en,
    input  logic [LEN_W-1:0] cfg_ext_len,
    output logic             urst_en,
    output logic [LEN_W-1:0] ext_len
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            urst_en <= 1'b0;
            ext_len <= '0;
        end else if (cfg_we && wr_open) begin
            urst_en <= cfg_urst_en;
            ext_len <= cfg_ext_len;
        end
    end
endmodule

// File: rtl/slowclk_reset_fsm.sv
module slowclk_reset_fsm
    import slowclk_reset_pkg::*;
#(
    parameter int STARTUP_LEN = 8,
    parameter int PROC_START  = 3,
    parameter int LEN_W       = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_sync,
    input  logic             urst_en,
    input  logic [LEN_W-1:0] ext_len,
    output logic             in_run,
    output logic             proc_rst_n,
    output logic             periph_rst_n,
    output logic             pin_drive_n,
    output logic [2:0]       rst_cause
);
    localparam int PULSE_BITS = (1 << LEN_W) + 1;
    localparam int START_BITS = $clog2(STARTUP_LEN + 1);
    localparam int PROC_BITS  = $clog2(PROC_START + 1);
    localparam int CNT_A      = (PULSE_BITS > START_BITS) ? PULSE_BITS : START_BITS;
    localparam int CNT_W      = (CNT_A > PROC_BITS) ? CNT_A : PROC_BITS;

    typedef logic [CNT_W-1:0] cnt_t;

    rst_state_e       state, state_nx;
    cnt_t             cnt, cnt_nx;
    logic [2:0]       cause_nx;
    logic [LEN_W:0]   shift_amt;
    cnt_t             pulse_len;

    assign shift_amt = {1'b0, ext_len} + (LEN_W+1)'(1);
    assign pulse_len = cnt_t'(1) << shift_amt;

    // next-state and counter decisions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        cause_nx = rst_cause;
        unique case (state)
            ST_STARTUP: begin
                if (cnt == cnt_t'(STARTUP_LEN - 1)) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                    cause_nx = CAUSE_POWERUP;
                end else begin
                    cnt_nx = cnt + cnt_t'(1);
                end
            end
            ST_RUN: begin
                if (!pin_sync && urst_en) begin
                    state_nx = ST_USER_HOLD;
                    cnt_nx   = pulse_len;
                end
            end
            ST_USER_HOLD: begin
                if (cnt != '0) begin
                    cnt_nx = cnt - cnt_t'(1);
                end else if (pin_sync) begin
                    state_nx = ST_PROC_START;
                    cnt_nx   = '0;
                end
            end
            ST_PROC_START: begin
                if (!pin_sync) begin
                    state_nx = ST_USER_HOLD;
                    cnt_nx   = '0;
                end else if (cnt == cnt_t'(PROC_START - 1)) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                    cause_nx = CAUSE_USER;
                end else begin
                    cnt_nx = cnt + cnt_t'(1);
                end
            end
            default: begin
                state_nx = ST_STARTUP;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state     <= ST_STARTUP;
            cnt       <= '0;
            rst_cause <= CAUSE_POWERUP;
        end else begin
            state     <= state_nx;
            cnt       <= cnt_nx;
            rst_cause <= cause_nx;
        end
    end

    // outputs
    always_comb begin
        in_run       = 1'b0;
        proc_rst_n   = 1'b0;
        periph_rst_n = 1'b0;
        pin_drive_n  = 1'b1;
        unique case (state)
            ST_STARTUP:    pin_drive_n = 1'b0;
            ST_RUN: begin
                in_run       = 1'b1;
                proc_rst_n   = 1'b1;
                periph_rst_n = 1'b1;
            end
            ST_USER_HOLD:  pin_drive_n = (cnt == '0);
            ST_PROC_START: pin_drive_n = 1'b1;
            default:       pin_drive_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/slowclk_reset_ctrl.sv
module slowclk_reset_ctrl #(
    parameter int STARTUP_LEN = 8,
    parameter int PROC_START  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_in,
    input  logic             cfg_we,
    input  logic             cfg_urst_en,
    input  logic [LEN_W-1:0] cfg_ext_len,
    output logic             proc_rst_n,
    output logic             periph_rst_n,
    output logic             pin_drive_n,
    output logic [2:0]       rst_cause
);
    logic             pin_sync;
    logic             in_run;
    logic             urst_en;
    logic [LEN_W-1:0] ext_len;

    slowclk_pin_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_in  (pin_in),
        .q_out (pin_sync)
    );

    slowclk_reset_cfg #(
        .LEN_W (LEN_W)
    ) u_cfg (
        .clk         (clk),
        .por_n       (por_n),
        .wr_open     (in_run),
        .cfg_we      (cfg_we),
        .cfg_urst_en (cfg_urst_en),
        .cfg_ext_len (cfg_ext_len),
        .urst_en     (urst_en),
        .ext_len     (ext_len)
    );

    slowclk_reset_fsm #(
        .STARTUP_LEN (STARTUP_LEN),
        .PROC_START  (PROC_START),
        .LEN_W       (LEN_W)
    ) u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .pin_sync     (pin_sync),
        .urst_en      (urst_en),
        .ext_len      (ext_len),
        .in_run       (in_run),
        .proc_rst_n   (proc_rst_n),
        .periph_rst_n (periph_rst_n),
        .pin_drive_n  (pin_drive_n),
        .rst_cause    (rst_cause)
    );
endmodule

// File: rtl/slowclk_reset_ctrl_chk.sv
module slowclk_reset_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       proc_rst_n,
    input logic       periph_rst_n,
    input logic       pin_drive_n,
    input logic [2:0] rst_cause
);
    p_all_low_in_por_r1: assert property (@(posedge clk)
        !por_n |-> (!proc_rst_n && !periph_rst_n && !pin_drive_n));

    p_resets_paired_r3: assert property (@(posedge clk) disable iff (!por_n)
        periph_rst_n == proc_rst_n);

    p_cause_moves_on_release_r6: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(rst_cause) |-> $rose(proc_rst_n));

    p_drive_only_in_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
        !pin_drive_n |-> !proc_rst_n);

    p_cause_legal_r11: assert property (@(posedge clk) disable iff (!por_n)
        (rst_cause == 3'd0) || (rst_cause == 3'd4));
endmodule

bind slowclk_reset_ctrl slowclk_reset_ctrl_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .proc_rst_n   (proc_rst_n),
    .periph_rst_n (periph_rst_n),
    .pin_drive_n  (pin_drive_n),
    .rst_cause    (rst_cause)
);

// File: tb/slowclk_reset_ctrl_test.sv
module slowclk_reset_ctrl_test;
    localparam int STARTUP = 8;
    localparam int WIN     = 40;
    localparam int NVEC    = 5;
    // {length code, pin-low cycles, expected drive-low cycles, expected reset-low cycles}
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{0, 1,  2,  6},
        '{1, 3,  4,  8},
        '{0, 10, 2, 13},
        '{2, 4,  8, 12},
        '{1, 5,  4,  8}
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_in = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_urst_en = 1'b0;
    logic [3:0] cfg_ext_len = 4'd0;
    logic       proc_rst_n, periph_rst_n, pin_drive_n;
    logic [2:0] rst_cause;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int m_proc, m_drive, m_mismatch;

    slowclk_reset_ctrl uut (
        .clk          (clk),
        .por_n        (por_n),
        .pin_in       (pin_in),
        .cfg_we       (cfg_we),
        .cfg_urst_en  (cfg_urst_en),
        .cfg_ext_len  (cfg_ext_len),
        .proc_rst_n   (proc_rst_n),
        .periph_rst_n (periph_rst_n),
        .pin_drive_n  (pin_drive_n),
        .rst_cause    (rst_cause)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    task automatic write_cfg(input bit en, input int len);
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_urst_en = en;
        cfg_ext_len = 4'(len);
        @(negedge clk);
        cfg_we      = 1'b0;
    endtask

    // pin low for hold edges, then count low samples over a window
    task automatic measure(input int hold);
        m_proc = 0; m_drive = 0; m_mismatch = 0;
        for (int i = 0; i <= WIN; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (!proc_rst_n)  m_proc++;
                if (!pin_drive_n) m_drive++;
                if (proc_rst_n != periph_rst_n) m_mismatch++;
            end
            pin_in = (i < hold) ? 1'b0 : 1'b1;
        end
        pin_in = 1'b1;
    endtask

    // power-on release, count startup-low samples
    task automatic power_up(input string req);
        @(negedge clk);
        por_n = 1'b1;
        m_proc = 0; m_drive = 0; m_mismatch = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!proc_rst_n)  m_proc++;
            if (!pin_drive_n) m_drive++;
            if (proc_rst_n != periph_rst_n) m_mismatch++;
        end
        check(m_proc == STARTUP - 1, req, m_proc, STARTUP - 1);
        check(m_drive == STARTUP - 1, req, m_drive, STARTUP - 1);
        check(m_mismatch == 0, "R3 startup pairing", m_mismatch, 0);
        check(rst_cause == 3'd0, "R11 cause after power-up", rst_cause, 0);
    endtask

    initial begin
        #1;
        // R1: reset state with no clock edge yet
        check(!proc_rst_n && !periph_rst_n && !pin_drive_n, "R1 initial outputs",
              {proc_rst_n, periph_rst_n, pin_drive_n}, 0);
        repeat (3) @(negedge clk);
        power_up("R2 startup length");

        // R9: enable defaults to 0 after power-on
        measure(4);
        check(m_proc == 0, "R9 default disabled", m_proc, 0);
        check(m_drive == 0, "R9 default disabled drive", m_drive, 0);

        // table walk: R4 R5 R7 R8 R6
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(1'b1, VEC[v][0]);
            measure(VEC[v][1]);
            check(m_drive == VEC[v][2], "R7 pulse width", m_drive, VEC[v][2]);
            check(m_proc == VEC[v][3], "R5 R8 reset span", m_proc, VEC[v][3]);
            check(m_mismatch == 0, "R3 pairing", m_mismatch, 0);
            check(rst_cause == 3'd4, "R6 user cause", rst_cause, 4);
        end

        // R4: assertion latency after first low sample
        write_cfg(1'b1, 0);
        @(negedge clk);
        pin_in = 1'b0;             // first sampled at next edge k
        @(negedge clk);            // after k
        check(proc_rst_n == 1'b1, "R4 not yet at k", proc_rst_n, 1);
        @(negedge clk);            // after k+1
        check(proc_rst_n == 1'b1, "R4 not yet at k+1", proc_rst_n, 1);
        @(negedge clk);            // after k+2
        check(proc_rst_n == 1'b0, "R4 asserted at k+2", proc_rst_n, 0);
        // R10: write while reset active
        write_cfg(1'b0, 3);
        pin_in = 1'b1;
        repeat (20) @(negedge clk);
        check(proc_rst_n == 1'b1, "R10 released", proc_rst_n, 1);
        measure(1);
        check(m_drive == 2, "R10 length kept", m_drive, 2);
        check(m_proc == 6, "R10 enable kept", m_proc, 6);

        // R9: disabled, cause stays 4
        write_cfg(1'b0, 1);
        measure(4);
        check(m_proc == 0, "R9 no reset", m_proc, 0);
        check(rst_cause == 3'd4, "R9 cause unchanged", rst_cause, 4);

        // R1: asynchronous assertion mid-run
        @(negedge clk);
        #2 por_n = 1'b0;
        #1;
        check(!proc_rst_n && !periph_rst_n && !pin_drive_n, "R1 async assert",
              {proc_rst_n, periph_rst_n, pin_drive_n}, 0);
        repeat (2) @(negedge clk);
        power_up("R2 second startup");

        finish_run();
    end
endmodule